// File: doc/BRIEF.md
# Timer Modulo Coherent Update Buffer

A 16-bit up-counting timer whose terminal count (the modulo) is loaded one byte at a time over an 8-bit register bus. Each modulo byte write lands in a holding buffer. The active modulo changes only when both halves have arrived, and the moment of that change depends on whether the timer clock is running. When the clock select is 00, the pair takes effect at once. When the clock select is nonzero, the pair waits for the next prescaled tick. If any other timer register is written while the pair is waiting, the pair is silently discarded. Firmware confirms an update by reading the modulo back: reads always return the active value, never the buffered one.

The block also holds the counter, an overflow flag with an interrupt enable, and the clock-select field. The prescaled tick arrives as a one-cycle input strobe. The bus is a plain register interface. Each write or read strobe is accepted in the cycle it is presented and there is no back-pressure, so no valid/ready stream is involved. Read data is combinational in the cycle of the read strobe.

Top module: `tmr_modbuf_top`

## Requirements
- R1: After reset, the counter is 0, the active modulo is 0, and the control register reads 0x00. Address map: 0 control, 1 counter high, 2 counter low, 3 modulo high, 4 modulo low. Control bits: bit 7 is the overflow flag, bit 6 is the interrupt enable, and bits 1:0 are the clock select. With nothing pending, irq is low.
- R2: A write of a single modulo byte never changes the modulo value read back at addresses 3 and 4.
- R3: With the clock select at 00, the new modulo reads back in the cycle right after the second byte of the pair is written.
- R4: With a nonzero clock select, a completed pair does not take effect until the next tick that follows the write. After that tick it reads back.
- R5: Writing to the control register or to either counter byte drops a waiting modulo pair or a partial pair. Later ticks do not apply the dropped value.
- R6: The two modulo bytes may be written in either order.
- R7: A write of any value to either counter address sets the counter to 0, and this takes priority over a tick in the same cycle.
- R8: The counter advances by one on each tick only while the clock select is nonzero. When the counter equals the modulo, the next tick wraps it to 0 and sets the overflow flag.
- R9: With a modulo of 0, the counter runs through 0xFFFF and wraps to 0 on the next tick, setting the overflow flag.
- R10: The overflow flag clears only on a control write with bit 7 at 0 that follows a control read made while the flag was set. Without that read, such a write leaves the flag set.
- R11: irq is high exactly when the overflow flag and the interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled timer tick strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach from the ports is a completed modulo pair that is still waiting, with the clock running, when a control or counter write arrives before any tick. The stimulus holds tick low, writes both bytes with a nonzero clock select, and then writes another register. Only after that does it release ticks and read the modulo back. The full-range wrap with a modulo of 0 needs 65536 ticks. For that, tick is held high continuously, and the counter and flag are read just before and just after the last tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned REG_ADDR_W = 3;
  localparam int unsigned CTRL_OVF_BIT = 7;
  localparam int unsigned CTRL_IE_BIT = 6;
  localparam int unsigned CLKSEL_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_CNT_HI = 3'd1,
    RA_CNT_LO = 3'd2,
    RA_MOD_HI = 3'd3,
    RA_MOD_LO = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/tmr_mod_buffer.sv
module tmr_mod_buffer #(
  parameter int unsigned BUS_W = 8,
  localparam int unsigned MOD_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [BUS_W-1:0] wdata,
  input  logic             cancel,
  input  logic             clk_on,
  input  logic             step,
  output logic [MOD_W-1:0] mod_act,
  output logic             pending
);
  logic             hi_seen, lo_seen;
  logic [BUS_W-1:0] hold_hi, hold_lo;
  logic             nxt_hi_seen, nxt_lo_seen, pair_done;
  logic [BUS_W-1:0] nxt_hold_hi, nxt_hold_lo;

  always_comb begin
    nxt_hi_seen = hi_seen | wr_hi;
    nxt_lo_seen = lo_seen | wr_lo;
    nxt_hold_hi = wr_hi ? wdata : hold_hi;
    nxt_hold_lo = wr_lo ? wdata : hold_lo;
    pair_done   = nxt_hi_seen & nxt_lo_seen;
  end

  assign pending = hi_seen & lo_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_seen <= 1'b0;
      lo_seen <= 1'b0;
      hold_hi <= '0;
      hold_lo <= '0;
      mod_act <= '0;
    end else if (cancel) begin
      hi_seen <= 1'b0;
      lo_seen <= 1'b0;
    end else if (wr_hi || wr_lo) begin
      hold_hi <= nxt_hold_hi;
      hold_lo <= nxt_hold_lo;
      if (pair_done && !clk_on) begin
        mod_act <= {nxt_hold_hi, nxt_hold_lo};
        hi_seen <= 1'b0;
        lo_seen <= 1'b0;
      end else begin
        hi_seen <= nxt_hi_seen;
        lo_seen <= nxt_lo_seen;
      end
    end else if (pending && step) begin
      mod_act <= {hold_hi, hold_lo};
      hi_seen <= 1'b0;
      lo_seen <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] term;
  logic             at_term;

  always_comb begin
    term    = (limit == '0) ? '1 : limit;
    at_term = (cnt == term);
    wrap    = step && at_term && !clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= at_term ? '0 : cnt + ONE;
  end
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ctrl,
  input  logic                rd_ctrl,
  input  logic                ovf_wbit,
  input  logic                ie_wbit,
  input  logic [CLKSEL_W-1:0] sel_wbits,
  input  logic                wrap_evt,
  output logic                ovf,
  output logic                ie,
  output logic [CLKSEL_W-1:0] clk_sel
);
  logic clr_armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie        <= 1'b0;
      clk_sel   <= '0;
      clr_armed <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ie        <= ie_wbit;
        clk_sel   <= sel_wbits;
        clr_armed <= 1'b0;
      end else if (rd_ctrl && ovf) begin
        clr_armed <= 1'b1;
      end
      if (wrap_evt)                               ovf <= 1'b1;
      else if (wr_ctrl && clr_armed && !ovf_wbit) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_modbuf_top.sv
module tmr_modbuf_top
  import tmr_pkg::*;
#(
  parameter int unsigned BUS_W = 8,
  parameter int unsigned ADDR_W = REG_ADDR_W,
  localparam int unsigned CNT_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              irq
);
  logic wr_ctrl, wr_cnt, wr_mhi, wr_mlo, rd_ctrl, other_wr;
  logic clk_on, cnt_step, wrap_evt, mod_pending;
  logic ovf_q, ie_q;
  logic [CLKSEL_W-1:0] clk_sel_q;
  logic [CNT_W-1:0]    mod_act, cnt_q;

  always_comb begin
    wr_ctrl  = wr_en && (addr == RA_CTRL);
    wr_cnt   = wr_en && ((addr == RA_CNT_HI) || (addr == RA_CNT_LO));
    wr_mhi   = wr_en && (addr == RA_MOD_HI);
    wr_mlo   = wr_en && (addr == RA_MOD_LO);
    rd_ctrl  = rd_en && (addr == RA_CTRL);
    other_wr = wr_ctrl || wr_cnt;
    clk_on   = |clk_sel_q;
    cnt_step = tick && clk_on;
  end

  tmr_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .rd_ctrl   (rd_ctrl),
    .ovf_wbit  (wdata[CTRL_OVF_BIT]),
    .ie_wbit   (wdata[CTRL_IE_BIT]),
    .sel_wbits (wdata[CLKSEL_W-1:0]),
    .wrap_evt  (wrap_evt),
    .ovf       (ovf_q),
    .ie        (ie_q),
    .clk_sel   (clk_sel_q)
  );

  tmr_mod_buffer #(.BUS_W(BUS_W)) u_modbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hi   (wr_mhi),
    .wr_lo   (wr_mlo),
    .wdata   (wdata),
    .cancel  (other_wr),
    .clk_on  (clk_on),
    .step    (cnt_step),
    .mod_act (mod_act),
    .pending (mod_pending)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (wr_cnt),
    .step  (cnt_step),
    .limit (mod_act),
    .cnt   (cnt_q),
    .wrap  (wrap_evt)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        RA_CTRL: begin
          rdata[CTRL_OVF_BIT]   = ovf_q;
          rdata[CTRL_IE_BIT]    = ie_q;
          rdata[CLKSEL_W-1:0]   = clk_sel_q;
        end
        RA_CNT_HI: rdata = cnt_q[CNT_W-1:BUS_W];
        RA_CNT_LO: rdata = cnt_q[BUS_W-1:0];
        RA_MOD_HI: rdata = mod_act[CNT_W-1:BUS_W];
        RA_MOD_LO: rdata = mod_act[BUS_W-1:0];
        default:   rdata = '0;
      endcase
    end
  end

  assign irq = ovf_q && ie_q;
endmodule

// File: rtl/tmr_modbuf_chk.sv
module tmr_modbuf_chk
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  wr_en,
  input logic [REG_ADDR_W-1:0] addr,
  input logic                  ovf_wbit,
  input logic                  irq,
  input logic                  ovf,
  input logic                  ie,
  input logic [CLKSEL_W-1:0]   clk_sel,
  input logic [CNT_W-1:0]      mod_act,
  input logic [CNT_W-1:0]      cnt
);
  logic w_mod, w_other, w_cnt;
  assign w_mod   = wr_en && ((addr == RA_MOD_HI) || (addr == RA_MOD_LO));
  assign w_cnt   = wr_en && ((addr == RA_CNT_HI) || (addr == RA_CNT_LO));
  assign w_other = w_cnt || (wr_en && (addr == RA_CTRL));

  assert_mod_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_act != $past(mod_act)) |-> ($past(w_mod) || $past(tick && (clk_sel != '0))));

  assert_cancel_keeps_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(w_other) |-> (mod_act == $past(mod_act)));

  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(w_cnt) |-> (cnt == '0));

  assert_cnt_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ($past(tick && (clk_sel != '0)) || $past(w_cnt)));

  assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf) |-> $past(wr_en && (addr == RA_CTRL) && !ovf_wbit));

  assert_irq_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($rose(ovf) || $rose(ie)));
endmodule

bind tmr_modbuf_top tmr_modbuf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .wr_en    (wr_en),
  .addr     (addr),
  .ovf_wbit (wdata[tmr_pkg::CTRL_OVF_BIT]),
  .irq      (irq),
  .ovf      (ovf_q),
  .ie       (ie_q),
  .clk_sel  (clk_sel_q),
  .mod_act  (mod_act),
  .cnt      (cnt_q)
);

// File: tb/tb_tmr_modbuf_top.sv
`timescale 1ns/1ps
module tb_tmr_modbuf_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  tmr_modbuf_top dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  localparam logic [2:0] A_CTRL = 3'd0, A_CHI = 3'd1, A_CLO = 3'd2,
                         A_MHI = 3'd3, A_MLO = 3'd4;

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // driver side: push the expected value, then present the read
  task automatic do_rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic do_tick(input int n);
    @(posedge clk); #1;
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  // monitor side: pop and compare at the falling edge of each read cycle
  always @(negedge clk) begin
    if (rd_en) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read actual=%02h expected=none", rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          bad++;
          $display("FAIL %s actual=%02h expected=%02h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    do_rd(A_CTRL, 8'h00, "R1 ctrl");
    do_rd(A_CHI, 8'h00, "R1 cnt hi");
    do_rd(A_CLO, 8'h00, "R1 cnt lo");
    do_rd(A_MHI, 8'h00, "R1 mod hi");
    do_rd(A_MLO, 8'h00, "R1 mod lo");
    chk_irq(1'b0, "R1 irq");

    // clock off: high byte first
    do_wr(A_MHI, 8'h12);
    do_rd(A_MHI, 8'h00, "R2 lone hi byte");
    do_rd(A_MLO, 8'h00, "R2 lone hi byte lo");
    do_wr(A_MLO, 8'h34);
    do_rd(A_MHI, 8'h12, "R3 immediate hi");
    do_rd(A_MLO, 8'h34, "R3 immediate lo");

    // R6 low byte first
    do_wr(A_MLO, 8'h05);
    do_rd(A_MLO, 8'h34, "R2 lone lo byte");
    do_wr(A_MHI, 8'h00);
    do_rd(A_MHI, 8'h00, "R6 lo-first hi");
    do_rd(A_MLO, 8'h05, "R6 lo-first lo");

    // R8 no counting with clock off
    do_tick(2);
    do_rd(A_CLO, 8'h00, "R8 clock off holds");

    do_wr(A_CTRL, 8'h01);
    do_tick(3);
    do_rd(A_CLO, 8'h03, "R8 count three");
    do_tick(2);
    do_rd(A_CLO, 8'h05, "R8 at modulo");
    do_rd(A_CTRL, 8'h01, "R8 no flag yet");
    do_tick(1);
    do_rd(A_CLO, 8'h00, "R8 wrapped");
    do_rd(A_CTRL, 8'h81, "R8 flag set");
    chk_irq(1'b0, "R11 enable off");

    // R11 / R10
    do_wr(A_CTRL, 8'hC1);
    chk_irq(1'b1, "R11 both set");
    do_wr(A_CTRL, 8'h41);
    do_rd(A_CTRL, 8'hC1, "R10 no prior read keeps flag");
    do_wr(A_CTRL, 8'h41);
    do_rd(A_CTRL, 8'h41, "R10 read then write clears");
    chk_irq(1'b0, "R11 flag clear");

    // R4 deferred commit
    do_wr(A_MHI, 8'h00);
    do_wr(A_MLO, 8'h08);
    do_rd(A_MLO, 8'h05, "R4 waits for tick");
    do_tick(1);
    do_rd(A_MLO, 8'h08, "R4 applied on tick");
    do_rd(A_CLO, 8'h01, "R8 count during commit tick");

    // R5 cancel by control write
    do_wr(A_MHI, 8'h00);
    do_wr(A_MLO, 8'h02);
    do_wr(A_CTRL, 8'h41);
    do_tick(2);
    do_rd(A_MLO, 8'h08, "R5 ctrl write drops pair");
    do_rd(A_CLO, 8'h03, "R8 count after cancel");

    // R5 cancel by counter write, R7 counter clear
    do_wr(A_MLO, 8'h03);
    do_wr(A_MHI, 8'h00);
    do_wr(A_CLO, 8'h77);
    do_rd(A_CLO, 8'h00, "R7 cnt lo cleared");
    do_rd(A_CHI, 8'h00, "R7 cnt hi cleared");
    do_tick(1);
    do_rd(A_MLO, 8'h08, "R5 cnt write drops pair");
    do_rd(A_CLO, 8'h01, "R7 counts from zero");

    // R9 full range
    do_wr(A_CHI, 8'h55);
    do_wr(A_MHI, 8'h00);
    do_wr(A_MLO, 8'h00);
    do_tick(65535);
    do_rd(A_MLO, 8'h00, "R9 modulo zero applied");
    do_rd(A_CHI, 8'hFF, "R9 top hi");
    do_rd(A_CLO, 8'hFF, "R9 top lo");
    do_rd(A_CTRL, 8'h41, "R9 no flag at top");
    do_tick(1);
    do_rd(A_CLO, 8'h00, "R9 wrapped lo");
    do_rd(A_CHI, 8'h00, "R9 wrapped hi");
    do_rd(A_CTRL, 8'hC1, "R9 flag set");
    chk_irq(1'b1, "R11 irq after wrap");

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      total++;
      bad++;
      $display("FAIL reads pending actual=%0d expected=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule